// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets an external two-wire bus master (I2C protocol) read and write a bank of eight 8-bit configuration registers. The serial clock and data lines are oversampled by a fast system clock. START, repeated START and STOP are decoded from the sampled lines. The slave drives the data line open-drain through an output-enable: when the enable is high, the pad pulls the line low.

The device address has seven bits. The high five bits are fixed at binary 10110 and the low two bits come from two strap inputs, so four of these slaves can share one bus. One register pointer serves every access. A write transaction loads the pointer from its first byte and stores each later byte at the pointer. A read transaction returns the byte at the pointer. The pointer wraps modulo eight in both directions. All register contents leave the block as one flat parallel bus, for use by the logic around it.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, all eight registers and the pointer are zero and the data-line enable is low (line released).
- R2: The slave acknowledges an address byte only when its upper seven bits equal 10110 followed by `addr_sel[1]`, `addr_sel[0]`. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R3: After an address that does not match, the slave acknowledges nothing and writes nothing until the next START.
- R4: Every byte the slave receives after a matching address is acknowledged by holding the data line low for the whole high period of the ninth clock pulse.
- R5: In a write transaction, the first byte after the address sets the pointer to its low three bits. Each later byte is stored at the pointer, and the pointer then advances modulo eight, so register 7 is followed by register 0.
- R6: If a STOP or a repeated START arrives before the eighth bit of a data byte has been completed by its falling clock edge, the byte is discarded. The target register and the pointer keep their values.
- R7: A random read works as follows. A write transaction sets the pointer, a repeated START follows, and the address is resent with the read bit. The slave then returns, most significant bit first, the register selected before the repeated START.
- R8: While reading, the pointer advances modulo eight after each byte the master acknowledges, and the next byte comes from the new pointer.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and waits for STOP or START. The pointer is not advanced.
- R10: The data-line enable changes only right after a detected falling clock edge, START or STOP. The data line driven by the slave is therefore stable while the clock is high.
- R11: A read transaction with no write transaction before it returns data starting from the pointer left by the previous transaction.
- R12: Register i appears on `regs_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at several times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, sampled asynchronously |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel | input | 2 | Strap pins that supply the two low device-address bits |
| sda_oe | output | 1 | High pulls the data line low; low releases it |
| regs_o | output | 64 | All eight registers; register i in bits 8*i+7 down to 8*i |

## Verification
The bench targets three areas. The first is transfers cut short. It sends a STOP after four bits, a STOP during the high phase of the eighth bit, and a repeated START after five bits. A design that commits on the eighth rising edge, or that counts bits loosely, would store a partial byte or move the pointer. The second is wrapping: sequential writes that run past register 7, and sequential reads that run past register 7. An off-by-one or a missing modulo would put data in the wrong slot or return the wrong byte. The third is addressing: wrong strap bits, a wrong fixed prefix, and changing the straps between transactions. Here a weak compare would acknowledge foreign traffic or write registers during another device's transfer. After a master NACK, the bench checks that the line is released and that a later read starts from the kept pointer.

// File: rtl/i2c_cfg_pkg.sv
// Package: shared types and constants for the two-wire configuration slave.
// Assumes 8-bit bytes on the bus; register width is fixed to the byte size.
package i2c_cfg_pkg;

    // Fixed upper five bits of the seven-bit device address.
    localparam logic [4:0] DEV_ID_HI = 5'b10110;

    // Byte-level protocol states of the slave engine.
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,   // bus free, waiting for START
        S_RX     = 3'd1,   // shifting in a byte from the master
        S_ACK    = 3'd2,   // slave holds the line low for the ninth bit
        S_TX     = 3'd3,   // shifting out a register byte
        S_MACK   = 3'd4,   // master acknowledge slot after a read byte
        S_IGNORE = 3'd5    // not addressed or read ended; wait for START/STOP
    } slv_state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_ADDR = 2'd0,     // device address plus direction bit
        K_PTR  = 2'd1,     // register pointer byte
        K_DATA = 2'd2      // register write data
    } rx_kind_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-bit synchronizer for asynchronous bus lines.
// Each line passes through STAGES flops (reset to the idle-high level); the
// flop after the last stage holds the previous synchronized value, so an
// edge detector downstream sees a clean current/previous pair.
// Assumes STAGES >= 2 and that line pulses last several system clocks.
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES:0] chain;

        // Shift the raw line through the synchronizer chain plus one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-1:0], din[g]};
            end
        end

        assign dout[g]  = chain[STAGES-1];
        assign dprev[g] = chain[STAGES];
    end

endmodule

// File: rtl/i2c_bus_events.sv
// Module: derives one-cycle bus event strobes from synchronized lines.
// Clock edges come from the clock line alone; START and STOP are data-line
// edges seen while the clock line is high in both the current and previous
// samples. Assumes inputs come from a synchronizer (no metastability here).
module i2c_bus_events (
    input  logic scl,
    input  logic sda,
    input  logic scl_prev,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    // Decode clock edges and the two bus conditions.
    always_comb begin
        scl_rise  = scl & ~scl_prev;
        scl_fall  = ~scl & scl_prev;
        bus_start = scl & scl_prev & sda_prev & ~sda;
        bus_stop  = scl & scl_prev & ~sda_prev & sda;
    end

endmodule

// File: rtl/i2c_reg_bank.sv
// Module: bank of NREG configuration registers with one write port and one
// combinational read port; the contents are also presented flat.
// Assumes NREG is a power of two so every pointer value selects a register.
module i2c_reg_bank #(
    parameter int NREG = 8,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(NREG)-1:0]  rd_addr,
    output logic [DW-1:0]            rd_data,
    output logic [NREG*DW-1:0]       regs_flat
);

    localparam int AW = $clog2(NREG);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;

        // Hold one register; load it when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                q <= wr_data;
            end
        end

        assign regs_flat[g*DW +: DW] = q;
    end

    // Read mux over the flat register image.
    assign rd_data = regs_flat[rd_addr*DW +: DW];

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: byte-level slave protocol engine.
// Receives address, pointer and data bytes, acknowledges them, commits
// writes on the falling edge that ends the eighth bit, and shifts register
// bytes out for reads. The line enable changes only on a clock falling edge,
// START or STOP. Assumes DW = 8 (address byte layout) and event strobes of
// one system clock from i2c_bus_events.
module i2c_slave_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_in,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [1:0]    addr_sel,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          sda_oe
);

    localparam int CW = $clog2(DW + 1);

    slv_state_t    st;
    rx_kind_t      kind;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic          rw;
    logic          mack;
    logic [AW-1:0] ptr;
    logic          oe;
    logic          byte_full;
    logic          addr_hit;

    // Byte completion and device-address match.
    always_comb begin
        byte_full = (cnt == CW'(DW));
        addr_hit  = (sh[DW-1 -: 7] == {DEV_ID_HI, addr_sel});
    end

    // Write strobe: data byte complete at the falling edge ending bit eight.
    always_comb begin
        wr_en   = (st == S_RX) && (kind == K_DATA) && scl_fall && byte_full
                  && !bus_start && !bus_stop;
        wr_addr = ptr;
        wr_data = sh;
        rd_addr = (st == S_MACK) ? ptr + AW'(1) : ptr;
        sda_oe  = oe;
    end

    // Protocol sequencing, shift register, bit counter, pointer and line enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            kind <= K_ADDR;
            cnt  <= '0;
            sh   <= '0;
            rw   <= 1'b0;
            mack <= 1'b0;
            ptr  <= '0;
            oe   <= 1'b0;
        end else if (bus_stop) begin
            st <= S_IDLE;
            oe <= 1'b0;
        end else if (bus_start) begin
            st   <= S_RX;
            kind <= K_ADDR;
            cnt  <= '0;
            oe   <= 1'b0;
        end else begin
            case (st)
                S_RX: begin
                    if (scl_rise && !byte_full) begin
                        sh  <= {sh[DW-2:0], sda_in};
                        cnt <= cnt + CW'(1);
                    end else if (scl_fall && byte_full) begin
                        cnt <= '0;
                        case (kind)
                            K_ADDR: begin
                                if (addr_hit) begin
                                    rw <= sh[0];
                                    oe <= 1'b1;
                                    st <= S_ACK;
                                end else begin
                                    st <= S_IGNORE;
                                end
                            end
                            K_PTR: begin
                                ptr <= sh[AW-1:0];
                                oe  <= 1'b1;
                                st  <= S_ACK;
                            end
                            default: begin
                                ptr <= ptr + AW'(1);
                                oe  <= 1'b1;
                                st  <= S_ACK;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        if (kind == K_ADDR && rw) begin
                            sh  <= rd_data;
                            oe  <= ~rd_data[DW-1];
                            cnt <= '0;
                            st  <= S_TX;
                        end else begin
                            oe   <= 1'b0;
                            st   <= S_RX;
                            kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (cnt == CW'(DW - 1)) begin
                            oe <= 1'b0;
                            st <= S_MACK;
                        end else begin
                            sh  <= {sh[DW-2:0], 1'b0};
                            oe  <= ~sh[DW-2];
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_in;
                    end else if (scl_fall) begin
                        if (mack) begin
                            ptr <= ptr + AW'(1);
                            sh  <= rd_data;
                            oe  <= ~rd_data[DW-1];
                            cnt <= '0;
                            st  <= S_TX;
                        end else begin
                            st <= S_IGNORE;
                        end
                    end
                end
                default: begin
                    oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_cfg_slave.sv
// Module: top of the two-wire configuration register slave.
// Synchronizes the bus lines, decodes bus events, runs the byte engine and
// holds the register bank. sda_oe high means the pad pulls the data line low.
// Assumes clk runs at least about eight times faster than the bus clock.
module i2c_cfg_slave #(
    parameter int NREG        = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [1:0]         addr_sel,
    output logic               sda_oe,
    output logic [NREG*DW-1:0] regs_o
);

    localparam int AW = $clog2(NREG);

    logic          scl_s, sda_s, scl_p, sda_p;
    logic          scl_rise, scl_fall, bus_start, bus_stop;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;

    i2c_line_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  ({scl_s, sda_s}),
        .dprev ({scl_p, sda_p})
    );

    i2c_bus_events u_events (
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_prev  (scl_p),
        .sda_prev  (sda_p),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_slave_fsm #(
        .DW (DW),
        .AW (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_s),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe)
    );

    i2c_reg_bank #(
        .NREG (NREG),
        .DW   (DW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
// Checker: temporal properties of the configuration slave, bound to the top.
// Observes the line enable, the synchronized clock line, the event strobes
// and the write strobe.
module i2c_cfg_slave_chk #(
    parameter int RW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          scl_fall,
    input logic          bus_start,
    input logic          bus_stop,
    input logic          wr_en,
    input logic [RW-1:0] regs_o
);

    // R1: the first cycle out of reset shows cleared registers and a released line.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sda_oe && regs_o == '0));

    // R10: the enable moves only after a falling clock edge, START or STOP.
    p_oe_after_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

    // R4: the slave starts pulling the line only while the clock is low.
    p_pull_in_low_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R9: after STOP the line is released.
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R6: a register is written only on a falling edge, never with a bus condition.
    p_write_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (scl_fall && !bus_start && !bus_stop));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.RW(NREG*DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .wr_en     (wr_en),
    .regs_o    (regs_o)
);

// File: tb/i2c_cfg_slave_test.sv
`timescale 1ns/1ps
// Bench: behavioural bus master plus a register/pointer reference model.
// The flat register output is compared with the model on every settled clock.
module i2c_cfg_slave_test;

    localparam int NREG = 8;
    localparam int DW   = 8;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] sel = 2'b10;
    logic sda_oe;
    logic [NREG*DW-1:0] regs_o;
    wire  sda_bus = sda_m & ~sda_oe;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int last_drive = 0;
    bit done = 1'b0;
    logic [7:0] mreg [NREG];
    int mptr = 0;

    always #2.5 clk = ~clk;

    i2c_cfg_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .addr_sel (sel),
        .sda_oe   (sda_oe),
        .regs_o   (regs_o)
    );

    function automatic logic [NREG*DW-1:0] model_flat();
        logic [NREG*DW-1:0] p;
        for (int i = 0; i < NREG; i++) p[i*DW +: DW] = mreg[i];
        return p;
    endfunction

    // R12: per-clock comparison of the register image once the bus has settled.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && !done && (cyc - last_drive > 6)) begin
            vectors++;
            if (regs_o !== model_flat()) begin
                fails++;
                $display("FAIL R12 regs_o: actual %h expected %h", regs_o, model_flat());
            end
        end
    end

    task automatic expect_eq(input string rq, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic d);
        scl_m = c;
        sda_m = d;
        last_drive = cyc;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
        return {5'b10110, s, rw};
    endfunction

    task automatic bus_start();
        drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
    endtask

    task automatic bus_stop();
        drive(0, 0); drive(1, 0); drive(1, 1);
    endtask

    // role: 0 none, 1 pointer byte, 2 data byte (model effect at the eighth fall)
    task automatic send_byte(input logic [7:0] b, input int role, input bit exp_ack, input string rq);
        for (int i = 7; i >= 0; i--) begin
            drive(0, b[i]);
            drive(1, b[i]);
            if (i == 0) begin
                if (role == 1) mptr = b[2:0];
                if (role == 2) begin mreg[mptr] = b; mptr = (mptr + 1) % NREG; end
            end
            drive(0, b[i]);
        end
        drive(0, 1);
        drive(1, 1);
        expect_eq(rq, sda_bus, exp_ack ? 1'b0 : 1'b1);
        drive(0, 1);
    endtask

    // Sends only the top n bits of b, then leaves the clock low.
    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            drive(0, b[i]); drive(1, b[i]); drive(0, b[i]);
        end
    endtask

    task automatic recv_byte(input bit mack, input string rq);
        logic [7:0] got;
        logic pre;
        logic [7:0] exp;
        exp = mreg[mptr];
        for (int i = 7; i >= 0; i--) begin
            drive(0, 1);
            pre = sda_bus;
            drive(1, 1);
            got[i] = sda_bus;
            expect_eq("R10 data stable while clock high", sda_bus, pre);
        end
        expect_eq(rq, got, exp);
        drive(0, mack ? 1'b0 : 1'b1);
        drive(1, mack ? 1'b0 : 1'b1);
        drive(0, mack ? 1'b0 : 1'b1);
        if (mack) mptr = (mptr + 1) % NREG;
        else expect_eq("R9 line released after NACK", sda_bus, 1'b1);
        drive(0, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        expect_eq("R1 registers cleared", regs_o, 64'h0);
        expect_eq("R1 line released", sda_oe, 1'b0);

        // R1/R11: read with no prior pointer write starts at register 0
        bus_start();
        send_byte(dev(sel, 1), 0, 1, "R2 read address ack");
        recv_byte(0, "R11 first read from reset pointer");
        bus_stop();

        // R4: single random write to register 2
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R4 address ack");
        send_byte(8'h02, 1, 1, "R4 pointer ack");
        send_byte(8'h3C, 2, 1, "R4 data ack");
        bus_stop();
        expect_eq("R4 register 2 written", regs_o[2*8 +: 8], 8'h3C);

        // R5: sequential write from 6 wraps into 0 and 1; pointer uses low three bits
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R5 address ack");
        send_byte(8'hF6, 1, 1, "R5 pointer ack");
        send_byte(8'hA1, 2, 1, "R5 data ack");
        send_byte(8'hA2, 2, 1, "R5 data ack");
        send_byte(8'hA3, 2, 1, "R5 data ack");
        send_byte(8'hA4, 2, 1, "R5 data ack");
        bus_stop();
        expect_eq("R5 wrap reached register 0", regs_o[0 +: 8], 8'hA3);
        expect_eq("R5 wrap reached register 1", regs_o[8 +: 8], 8'hA4);

        // R2/R3: wrong strap bits and wrong prefix are not acknowledged; data ignored
        bus_start();
        send_byte(dev(2'b01, 0), 0, 0, "R2 strap mismatch no ack");
        send_byte(8'h04, 0, 0, "R3 no ack while ignoring");
        send_byte(8'h55, 0, 0, "R3 no ack while ignoring");
        bus_stop();
        bus_start();
        send_byte({5'b00110, sel, 1'b0}, 0, 0, "R2 prefix mismatch no ack");
        bus_stop();
        expect_eq("R3 nothing written", regs_o, model_flat());

        // R2: new strap value changes the address that is acknowledged
        sel = 2'b01;
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R2 new strap address ack");
        send_byte(8'h05, 1, 1, "R2 pointer ack");
        send_byte(8'h77, 2, 1, "R2 data ack");
        bus_stop();

        // R6: STOP after four data bits
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R6 address ack");
        send_byte(8'h03, 1, 1, "R6 pointer ack");
        send_bits(8'hFF, 4);
        bus_stop();
        expect_eq("R6 stop mid byte discarded", regs_o[3*8 +: 8], 8'h00);

        // R6: STOP during the high phase of the eighth bit
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R6 address ack");
        send_byte(8'h03, 1, 1, "R6 pointer ack");
        send_bits(8'hEE, 7);
        drive(0, 0); drive(1, 0); drive(1, 1);
        expect_eq("R6 stop on eighth bit discarded", regs_o[3*8 +: 8], 8'h00);

        // R6/R7: repeated START after five bits, then read the kept pointer
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R7 address ack");
        send_byte(8'h05, 1, 1, "R7 pointer ack");
        send_bits(8'h99, 5);
        bus_start();
        expect_eq("R6 repeated start discarded", regs_o[5*8 +: 8], 8'h77);
        send_byte(dev(sel, 1), 0, 1, "R7 read address ack");
        recv_byte(0, "R7 random read after abort");
        bus_stop();

        // R7/R8: random read at 6 then sequential across the wrap
        bus_start();
        send_byte(dev(sel, 0), 0, 1, "R7 address ack");
        send_byte(8'h06, 1, 1, "R7 pointer ack");
        bus_start();
        send_byte(dev(sel, 1), 0, 1, "R7 read address ack");
        recv_byte(1, "R7 random read register 6");
        recv_byte(1, "R8 sequential read register 7");
        recv_byte(0, "R8 sequential read wraps to register 0");
        bus_stop();

        // R11/R9: next read resumes from the pointer kept after the NACK
        bus_start();
        send_byte(dev(sel, 1), 0, 1, "R11 read address ack");
        recv_byte(1, "R11 read resumes at kept pointer");
        recv_byte(0, "R8 next byte after ack");
        bus_stop();
        expect_eq("R9 line idle after stop", sda_bus, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule